// File: doc/BRIEF.md
# UART Modem Handshake Controller

This block handles the hardware handshake lines of a UART. It sits between the serial transmit and receive engines and the two modem pins. On the receive side it holds off the remote sender when the local receive FIFO is close to full. It does this by comparing the FIFO byte count against a programmable threshold and driving the ready-to-send pin. Software can take over that pin directly, and the pin polarity can be inverted.

On the transmit side, the incoming clear-to-send pin passes through a clock-domain synchronizer. Software picks the active level. The result gates the start of each new transmit frame. A frame that has already started always runs to its stop bit. Every transition of the sampled clear-to-send level sets a sticky detect flag. When enabled, that flag raises the modem interrupt until software clears it.

The serial shifters and FIFO storage live elsewhere. This block sees only the FIFO count, a frame-start strobe and a frame-done strobe from the transmitter, and the configuration fields.

Top module: `uart_flow_ctl`

## Requirements
- R1: While `rstN` is low, `rtsPin` is 1, `ctsDetect` and `modemIrq` are 0, and `txPermit` is 1 when `autoCtsEn` is 0.
- R2: With `autoRtsEn`=1, the internal ready signal is active when `rxFifoCnt` < `rtsTrigLvl` and inactive when the count is equal or greater. `rtsPin` reflects this one clock after the inputs change.
- R3: With `autoRtsEn`=1 and `rtsTrigLvl`=0, the ready signal is always inactive, whatever the count.
- R4: With `autoRtsEn`=0, the ready signal follows `swRtsAct` (1 = active), and `rxFifoCnt` has no effect on `rtsPin`.
- R5: With `rtsInvert`=0, `rtsPin` is 0 when ready is active and 1 when inactive. With `rtsInvert`=1, the pin levels are swapped. `rtsStatus` always equals the level on `rtsPin`.
- R6: `ctsStatus` shows the level of `ctsPinN` two clock edges after the pin changes.
- R7: `ctsActHigh`=0 makes a low sampled level count as clear-to-send. `ctsActHigh`=1 makes a high level count.
- R8: Each transition of the sampled level sets `ctsDetect` exactly once, one clock after `ctsStatus` changes. Changing `ctsActHigh` alone never sets it.
- R9: `ctsDetect` stays set until a one-cycle `detectClr` pulse clears it. A clear in the same cycle as a new transition leaves the flag set.
- R10: `modemIrq` is high exactly while `ctsDetect` and `modemIntEn` are both high.
- R11: With `autoCtsEn`=1, `txPermit` is high only while no frame is in progress and clear-to-send is active. With `autoCtsEn`=0, it is high whenever no frame is in progress.
- R12: `txStart` while `txPermit` is high begins a frame, and `txPermit` drops the next cycle. It stays low until `txDone`, even if clear-to-send goes inactive mid-frame. `txStart` while `txPermit` is low is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| autoRtsEn | input | 1 | 1 = ready pin driven by FIFO threshold |
| swRtsAct | input | 1 | Software ready value, 1 = active |
| rtsInvert | input | 1 | 1 = swap ready pin levels |
| rtsTrigLvl | input | LVL_W | FIFO threshold |
| rxFifoCnt | input | CNT_W | Bytes held in receive FIFO |
| rtsPin | output | 1 | Ready-to-send pin drive |
| rtsStatus | output | 1 | Readback of ready pin level |
| ctsPinN | input | 1 | Asynchronous clear-to-send pin |
| ctsActHigh | input | 1 | 1 = high pin level is active |
| autoCtsEn | input | 1 | 1 = gate frame starts on clear-to-send |
| modemIntEn | input | 1 | Modem interrupt enable |
| detectClr | input | 1 | Clear pulse for the detect flag |
| ctsStatus | output | 1 | Synchronized clear-to-send pin level |
| ctsDetect | output | 1 | Sticky transition flag |
| modemIrq | output | 1 | Modem interrupt |
| txStart | input | 1 | Transmitter begins a frame |
| txDone | input | 1 | Transmitter finished the stop bit |
| txPermit | output | 1 | A new frame may start |

## Verification
Corrupting the synchronizer or the previous-level register shows up first as a missing or duplicated `ctsDetect` set, three edges after the pin moves, and then as `txPermit` disagreeing with `ctsStatus`. If the frame state machine loses its busy state, `txPermit` reappears mid-frame as soon as clear-to-send returns, instead of waiting for `txDone`. A wrong threshold compare or polarity shows on `rtsPin` one clock after the FIFO count crosses the threshold.

// File: rtl/flowctl_pkg.sv
package flowctl_pkg;
  typedef struct packed {
    logic ctsChange;
    logic ctsLevel;
  } ctsEvt_t;

  typedef enum logic {TX_IDLE = 1'b0, TX_BUSY = 1'b1} txState_e;
endpackage

// File: rtl/flowctl_ctrl.sv
module flowctl_ctrl
  import flowctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ctsPinN,
  input  logic    ctsActHigh,
  input  logic    autoCtsEn,
  input  logic    txStart,
  input  logic    txDone,
  output ctsEvt_t evt,
  output logic    txPermit
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic sampled, prevQ, ctsActive;
  txState_e txState;

  // synchronizer chain, single-stage variant when asked for
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= ctsPinN;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ctsPinN};
      end
    end
  endgenerate

  assign sampled = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b1;
    else       prevQ <= sampled;
  end

  assign evt.ctsChange = sampled ^ prevQ;
  assign evt.ctsLevel  = sampled;
  assign ctsActive     = ctsActHigh ? sampled : ~sampled;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState <= TX_IDLE;
    end else begin
      unique case (txState)
        TX_IDLE: if (txStart && txPermit) txState <= TX_BUSY;
        TX_BUSY: if (txDone)              txState <= TX_IDLE;
        default:                          txState <= TX_IDLE;
      endcase
    end
  end

  assign txPermit = (txState == TX_IDLE) && (!autoCtsEn || ctsActive);
endmodule

// File: rtl/flowctl_dp.sv
module flowctl_dp
  import flowctl_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int LVL_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoRtsEn,
  input  logic             swRtsAct,
  input  logic             rtsInvert,
  input  logic [LVL_W-1:0] rtsTrigLvl,
  input  logic [CNT_W-1:0] rxFifoCnt,
  input  logic             modemIntEn,
  input  logic             detectClr,
  input  ctsEvt_t          evt,
  output logic             rtsPin,
  output logic             ctsStatus,
  output logic             ctsDetect,
  output logic             modemIrq
);
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

  logic [CMP_W-1:0] cntExt, lvlExt;
  logic readyAct;

  assign cntExt = CMP_W'(rxFifoCnt);
  assign lvlExt = CMP_W'(rtsTrigLvl);

  // a zero threshold can never be undercut, so ready stays inactive
  assign readyAct = autoRtsEn ? (cntExt < lvlExt) : swRtsAct;

  always_ff @(posedge clk) begin
    if (!rstN) rtsPin <= 1'b1;
    else       rtsPin <= (~readyAct) ^ rtsInvert;
  end

  always_ff @(posedge clk) begin
    if (!rstN) ctsDetect <= 1'b0;
    else       ctsDetect <= evt.ctsChange | (ctsDetect & ~detectClr);
  end

  assign ctsStatus = evt.ctsLevel;
  assign modemIrq  = ctsDetect & modemIntEn;
endmodule

// File: rtl/uart_flow_ctl.sv
module uart_flow_ctl
  import flowctl_pkg::*;
#(
  parameter int CNT_W       = 5,
  parameter int LVL_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             autoRtsEn,
  input  logic             swRtsAct,
  input  logic             rtsInvert,
  input  logic [LVL_W-1:0] rtsTrigLvl,
  input  logic [CNT_W-1:0] rxFifoCnt,
  output logic             rtsPin,
  output logic             rtsStatus,
  input  logic             ctsPinN,
  input  logic             ctsActHigh,
  input  logic             autoCtsEn,
  input  logic             modemIntEn,
  input  logic             detectClr,
  output logic             ctsStatus,
  output logic             ctsDetect,
  output logic             modemIrq,
  input  logic             txStart,
  input  logic             txDone,
  output logic             txPermit
);
  ctsEvt_t evt;

  flowctl_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .ctsPinN(ctsPinN), .ctsActHigh(ctsActHigh),
    .autoCtsEn(autoCtsEn), .txStart(txStart), .txDone(txDone),
    .evt(evt), .txPermit(txPermit)
  );

  flowctl_dp #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_dp (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .swRtsAct(swRtsAct),
    .rtsInvert(rtsInvert), .rtsTrigLvl(rtsTrigLvl), .rxFifoCnt(rxFifoCnt),
    .modemIntEn(modemIntEn), .detectClr(detectClr), .evt(evt),
    .rtsPin(rtsPin), .ctsStatus(ctsStatus), .ctsDetect(ctsDetect),
    .modemIrq(modemIrq)
  );

  assign rtsStatus = rtsPin;
endmodule

// File: rtl/uart_flow_ctl_chk.sv
module uart_flow_ctl_chk #(
  parameter int CNT_W = 5,
  parameter int LVL_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             autoRtsEn,
  input logic             swRtsAct,
  input logic             rtsInvert,
  input logic [LVL_W-1:0] rtsTrigLvl,
  input logic [CNT_W-1:0] rxFifoCnt,
  input logic             rtsPin,
  input logic             ctsActHigh,
  input logic             autoCtsEn,
  input logic             modemIntEn,
  input logic             detectClr,
  input logic             ctsStatus,
  input logic             ctsDetect,
  input logic             modemIrq,
  input logic             txStart,
  input logic             txPermit
);
  localparam int CMP_W = (CNT_W > LVL_W) ? CNT_W : LVL_W;
  logic [CMP_W-1:0] cntX, lvlX;
  assign cntX = CMP_W'(rxFifoCnt);
  assign lvlX = CMP_W'(rtsTrigLvl);

  p_auto_thresh_r2: assert property (@(posedge clk) disable iff (!rstN)
    autoRtsEn |=> rtsPin == (($past(cntX) < $past(lvlX)) ? $past(rtsInvert) : ~$past(rtsInvert)));

  p_zero_level_r3: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && rtsTrigLvl == '0) |=> rtsPin == ~$past(rtsInvert));

  p_sw_follow_r4: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |=> rtsPin == (~$past(swRtsAct) ^ $past(rtsInvert)));

  p_detect_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ctsStatus) |=> ctsDetect);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (ctsDetect && !detectClr) |=> ctsDetect);

  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    modemIrq |-> (ctsDetect && modemIntEn));

  p_cts_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    (autoCtsEn && (ctsStatus != ctsActHigh)) |-> !txPermit);

  p_busy_after_start_r12: assert property (@(posedge clk) disable iff (!rstN)
    (txStart && txPermit) |=> !txPermit);
endmodule

bind uart_flow_ctl uart_flow_ctl_chk #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .swRtsAct(swRtsAct),
  .rtsInvert(rtsInvert), .rtsTrigLvl(rtsTrigLvl), .rxFifoCnt(rxFifoCnt),
  .rtsPin(rtsPin), .ctsActHigh(ctsActHigh), .autoCtsEn(autoCtsEn),
  .modemIntEn(modemIntEn), .detectClr(detectClr), .ctsStatus(ctsStatus),
  .ctsDetect(ctsDetect), .modemIrq(modemIrq), .txStart(txStart),
  .txPermit(txPermit)
);

// File: tb/uart_flow_ctl_test.sv
`timescale 1ns/100ps
module uart_flow_ctl_test;
  localparam int CNT_W = 5;
  localparam int LVL_W = 4;

  localparam int S_RTS = 0, S_RSTAT = 1, S_CSTAT = 2, S_DET = 3, S_IRQ = 4, S_PERMIT = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoRtsEn = 0, swRtsAct = 0, rtsInvert = 0;
  logic [LVL_W-1:0] rtsTrigLvl = '0;
  logic [CNT_W-1:0] rxFifoCnt = '0;
  logic ctsPinN = 1, ctsActHigh = 0, autoCtsEn = 0, modemIntEn = 0, detectClr = 0;
  logic txStart = 0, txDone = 0;
  logic rtsPin, rtsStatus, ctsStatus, ctsDetect, modemIrq, txPermit;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  string tagQ[$];
  int    selQ[$];
  bit    expQ[$];

  always #2.5 clk = ~clk;

  uart_flow_ctl #(.CNT_W(CNT_W), .LVL_W(LVL_W), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .swRtsAct(swRtsAct),
    .rtsInvert(rtsInvert), .rtsTrigLvl(rtsTrigLvl), .rxFifoCnt(rxFifoCnt),
    .rtsPin(rtsPin), .rtsStatus(rtsStatus), .ctsPinN(ctsPinN),
    .ctsActHigh(ctsActHigh), .autoCtsEn(autoCtsEn), .modemIntEn(modemIntEn),
    .detectClr(detectClr), .ctsStatus(ctsStatus), .ctsDetect(ctsDetect),
    .modemIrq(modemIrq), .txStart(txStart), .txDone(txDone), .txPermit(txPermit)
  );

  function automatic bit pick(int sel);
    case (sel)
      S_RTS:    return rtsPin;
      S_RSTAT:  return rtsStatus;
      S_CSTAT:  return ctsStatus;
      S_DET:    return ctsDetect;
      S_IRQ:    return modemIrq;
      default:  return txPermit;
    endcase
  endfunction

  // monitor: compares queued expectations against the outputs at the falling edge
  always @(negedge clk) begin
    while (tagQ.size() > 0) begin
      string t;
      int s;
      bit e, a;
      t = tagQ.pop_front();
      s = selQ.pop_front();
      e = expQ.pop_front();
      a = pick(s);
      nChecks++;
      if (a !== e) begin
        nFail++;
        $display("FAIL %s sel=%0d actual=%0b expected=%0b at %0t", t, s, a, e, $time);
      end
    end
  end

  task automatic push(string tag, int sel, bit exp);
    tagQ.push_back(tag);
    selQ.push_back(sel);
    expQ.push_back(exp);
  endtask

  task automatic settle();
    @(negedge clk);
    #0.5;
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    tick(3);
    push("R1 rtsPin", S_RTS, 1);
    push("R1 detect", S_DET, 0);
    push("R1 irq", S_IRQ, 0);
    push("R1 permit", S_PERMIT, 1);
    settle();
    tick(1);
    rstN = 1;
    tick(2);

    // R4 software mode
    swRtsAct = 1;
    tick(1);
    push("R4 sw active", S_RTS, 0);
    settle();
    tick(1);
    rxFifoCnt = 5'd20; rtsTrigLvl = 4'd4;
    tick(2);
    push("R4 count ignored", S_RTS, 0);
    settle();
    tick(1);
    swRtsAct = 0;
    tick(1);
    push("R4 sw inactive", S_RTS, 1);
    settle();

    // R5 polarity and readback
    tick(1);
    rtsInvert = 1;
    tick(1);
    push("R5 inverted inactive", S_RTS, 0);
    push("R5 readback", S_RSTAT, 0);
    settle();
    tick(1);
    swRtsAct = 1;
    tick(1);
    push("R5 inverted active", S_RTS, 1);
    push("R5 readback hi", S_RSTAT, 1);
    settle();

    // R2 threshold mode
    tick(1);
    rtsInvert = 0; autoRtsEn = 1; rtsTrigLvl = 4'd8; rxFifoCnt = 5'd7;
    tick(1);
    push("R2 below", S_RTS, 0);
    settle();
    tick(1);
    rxFifoCnt = 5'd8;
    tick(1);
    push("R2 equal", S_RTS, 1);
    settle();
    tick(1);
    rxFifoCnt = 5'd15;
    tick(1);
    push("R2 above", S_RTS, 1);
    settle();
    tick(1);
    rtsTrigLvl = 4'd15; rxFifoCnt = 5'd14;
    tick(1);
    push("R2 max level below", S_RTS, 0);
    settle();
    tick(1);
    rtsTrigLvl = 4'd8; rxFifoCnt = 5'd9; swRtsAct = 1;
    tick(1);
    push("R2 sw value ignored", S_RTS, 1);
    settle();

    // R3 zero threshold
    tick(1);
    rtsTrigLvl = 4'd0; rxFifoCnt = 5'd0;
    tick(1);
    push("R3 zero level", S_RTS, 1);
    settle();
    tick(1);
    autoRtsEn = 0; swRtsAct = 0;

    // R6 R8 exact timing of sampling and detect
    tick(1);
    ctsPinN = 0;
    tick(1);
    push("R6 one edge", S_CSTAT, 1);
    settle();
    tick(1);
    push("R6 two edges", S_CSTAT, 0);
    push("R8 not yet", S_DET, 0);
    settle();
    tick(1);
    push("R8 detect set", S_DET, 1);
    push("R10 irq masked", S_IRQ, 0);
    settle();

    // R10 enable
    tick(1);
    modemIntEn = 1;
    #0.5;
    push("R10 irq on", S_IRQ, 1);
    settle();

    // R9 sticky then clear
    tick(4);
    push("R9 sticky", S_DET, 1);
    settle();
    tick(1);
    detectClr = 1;
    tick(1);
    detectClr = 0;
    push("R9 cleared", S_DET, 0);
    push("R10 irq off", S_IRQ, 0);
    settle();
    tick(5);
    push("R8 exactly once", S_DET, 0);
    settle();

    // R8 polarity change alone
    tick(1);
    ctsActHigh = 1;
    tick(4);
    push("R8 polarity no detect", S_DET, 0);
    settle();
    tick(1);
    ctsActHigh = 0;

    // R9 clear coinciding with a new transition
    tick(1);
    ctsPinN = 1;
    tick(2);
    detectClr = 1;
    tick(1);
    detectClr = 0;
    push("R9 set wins over clear", S_DET, 1);
    settle();
    tick(1);
    detectClr = 1;
    tick(1);
    detectClr = 0;
    modemIntEn = 0;

    // R11 gating by clear-to-send, pin currently high (inactive for low-active)
    autoCtsEn = 1;
    #0.5;
    push("R11 inactive blocks", S_PERMIT, 0);
    settle();
    tick(1);
    ctsPinN = 0;
    tick(2);
    push("R11 active permits", S_PERMIT, 1);
    settle();
    tick(1);
    ctsActHigh = 1;
    #0.5;
    push("R7 high-active blocks low pin", S_PERMIT, 0);
    settle();
    tick(1);
    ctsActHigh = 0; ctsPinN = 1;
    tick(3);
    autoCtsEn = 0;
    #0.5;
    push("R11 auto off permits", S_PERMIT, 1);
    settle();

    // R12 frame in progress
    tick(1);
    autoCtsEn = 1; ctsPinN = 0;
    tick(3);
    txStart = 1;
    tick(1);
    txStart = 0;
    push("R12 busy after start", S_PERMIT, 0);
    settle();
    tick(1);
    ctsPinN = 1;
    tick(4);
    push("R12 frame not aborted", S_PERMIT, 0);
    settle();
    tick(1);
    txDone = 1;
    tick(1);
    txDone = 0;
    push("R12 done but cts off", S_PERMIT, 0);
    settle();
    tick(1);
    ctsPinN = 0;
    tick(3);
    push("R12 resumes", S_PERMIT, 1);
    settle();
    tick(1);
    txStart = 1;
    tick(1);
    txStart = 0;
    tick(2);
    push("R12 busy mid frame", S_PERMIT, 0);
    settle();
    tick(1);
    txDone = 1;
    tick(1);
    txDone = 0;
    push("R12 idle after done", S_PERMIT, 1);
    settle();

    // R12 start ignored when not permitted
    tick(1);
    ctsPinN = 1;
    tick(3);
    txStart = 1;
    tick(1);
    txStart = 0;
    ctsPinN = 0;
    tick(3);
    push("R12 blocked start ignored", S_PERMIT, 1);
    settle();

    tick(2);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule